// File: doc/BRIEF.md
# Dual-Port Semaphore Latch Bank

This block holds a bank of single-bit ownership latches that two independent ports, called left and right, use to reserve shared resources. It sits beside a dual-port memory but keeps no data words. A port claims a latch by writing a zero to it and gives it back by writing a one. Each port then reads its own view of the latch: zero means "this port owns it" and one means "this port does not own it".

Each latch also remembers a claim from the side that does not hold it. When the holder releases, that waiting side becomes the owner in the same clock step. A waiting side can withdraw its claim by writing a one. If both sides claim the same free latch in the same cycle, the left side wins and the right side's claim waits.

Read results go into a per-port output register and stay there until that port makes its next valid read. A write from the other port cannot change a result that has already been read. All transfers are synchronous to one clock. The strobes are sampled on its rising edge.

Top module: `sem_bank`

## Requirements
- R1: After reset, every latch is free and has no waiting claim. Both output registers hold all ones.
- R2: A port's access is valid only when its `*_sem_sel` is 1 and its `*_mem_en` is 0. A write or read strobe outside a valid access changes no latch and leaves that port's output register unchanged.
- R3: The latch index is address bits [2:0]. All higher address bits have no effect on which latch is accessed.
- R4: A write uses the single data bit: 0 claims, 1 releases or withdraws. A claim on a free latch makes the writer the owner. The writer then reads 0 and the other port reads 1.
- R5: Only the owner can change a held latch's ownership. A write of 1 by the non-owner with no waiting claim leaves ownership as it is. A repeated claim by the owner also changes nothing.
- R6: A release by the owner with no waiting claim frees the latch, and both ports then read 1.
- R7: A claim by the non-owner while the latch is held is queued. When the owner releases, the queued side becomes the owner in that same clock step. It then reads 0 and the former owner reads 1.
- R8: A queued side that writes 1 withdraws its claim. A later release by the owner then frees the latch.
- R9: Claims from both ports on the same free latch in the same cycle give ownership to the left port, and the right port's claim is queued.
- R10: A valid read loads all output bits with that port's view in the cycle after the strobe. The view is taken before any write in that same cycle. The register holds its value until the port's next valid read.
- R11: The latches are independent: an access to one index never changes the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left memory enable; must be 0 for a semaphore access |
| l_addr | input | AW | Left address; bits [2:0] pick the latch |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_din | input | 1 | Left write bit: 0 claims, 1 releases |
| l_dout | output | DW | Left read register, every bit is the left view |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right memory enable; must be 0 for a semaphore access |
| r_addr | input | AW | Right address; bits [2:0] pick the latch |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_din | input | 1 | Right write bit: 0 claims, 1 releases |
| r_dout | output | DW | Right read register, every bit is the right view |

## Verification
The bench targets the handover on release. A design that dropped the queued claim would free the latch instead of passing it to the waiting port. A design that ignored a withdrawal would hand the latch to a port that no longer wants it. It drives same-cycle claims from both ports, where a wrong arbiter would give the latch to the right port or to both. It also tests a non-owner writing a one, which a careless design would treat as a release. Further checks cover a read issued in the same cycle as a release, which must return the view from before the release. They also cover address bits above bit 2 and accesses with the memory enable active, which a loose decoder would wrongly accept.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } cell_s;

    localparam cell_s CELL_RESET = '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int AW   = 14,
    parameter int NSEM = 8,
    localparam int IW  = $clog2(NSEM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sem_sel,
    input  logic            mem_en,
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            rd,
    input  logic            din,
    output logic [NSEM-1:0] claim_vec,
    output logic [NSEM-1:0] drop_vec,
    output logic            rd_en,
    output logic [IW-1:0]   idx
);

    logic valid;

    always_comb begin
        valid     = sem_sel & ~mem_en;
        idx       = addr[IW-1:0];
        claim_vec = '0;
        drop_vec  = '0;
        if (valid && wr) begin
            if (din) drop_vec[idx]  = 1'b1;
            else     claim_vec[idx] = 1'b1;
        end
        rd_en = valid & rd;
    end

    // R3: at most one latch is touched per write
    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec | drop_vec));

    // R2: no effect without a valid access
    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sem_sel || mem_en) |-> (claim_vec == '0 && drop_vec == '0 && !rd_en));

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_claim,
    input  logic l_drop,
    input  logic r_claim,
    input  logic r_drop,
    output logic l_owns,
    output logic r_owns
);

    cell_s cell_q, cell_d;
    logic  wl, wr_;

    always_comb begin
        cell_d = cell_q;
        wl     = cell_q.wait_l;
        wr_    = cell_q.wait_r;
        unique case (cell_q.owner)
            OWN_NONE: begin
                if (l_claim) begin
                    cell_d.owner = OWN_LEFT;
                    wr_          = r_claim;
                    wl           = 1'b0;
                end else if (r_claim) begin
                    cell_d.owner = OWN_RIGHT;
                    wl           = 1'b0;
                    wr_          = 1'b0;
                end else begin
                    wl  = 1'b0;
                    wr_ = 1'b0;
                end
            end
            OWN_LEFT: begin
                if (r_claim)     wr_ = 1'b1;
                else if (r_drop) wr_ = 1'b0;
                if (l_drop) begin
                    if (wr_) begin
                        cell_d.owner = OWN_RIGHT;
                        wr_          = 1'b0;
                    end else begin
                        cell_d.owner = OWN_NONE;
                    end
                end
                wl = 1'b0;
            end
            OWN_RIGHT: begin
                if (l_claim)     wl = 1'b1;
                else if (l_drop) wl = 1'b0;
                if (r_drop) begin
                    if (wl) begin
                        cell_d.owner = OWN_LEFT;
                        wl           = 1'b0;
                    end else begin
                        cell_d.owner = OWN_NONE;
                    end
                end
                wr_ = 1'b0;
            end
            default: begin
                cell_d.owner = OWN_NONE;
                wl           = 1'b0;
                wr_          = 1'b0;
            end
        endcase
        cell_d.wait_l = wl;
        cell_d.wait_r = wr_;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= CELL_RESET;
        else        cell_q <= cell_d;
    end

    assign l_owns = (cell_q.owner == OWN_LEFT);
    assign r_owns = (cell_q.owner == OWN_RIGHT);

    // R7: the owner never also has a queued claim
    assert_no_self_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_owns && cell_q.wait_l) && !(r_owns && cell_q.wait_r));

    // R5: left holding stays left unless left releases
    assert_hold_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_owns && !l_drop) |=> l_owns);

    assert_hold_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_owns && !r_drop) |=> r_owns);

    // R9: left wins a free latch
    assert_left_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.owner == OWN_NONE && l_claim) |=> l_owns);

    // R7: queued right takes over on left release
    assert_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_owns && cell_q.wait_r && !r_drop && l_drop) |=> r_owns);

    // R6: release with nobody waiting frees the latch
    assert_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_owns && !cell_q.wait_r && !r_claim && l_drop) |=> (!l_owns && !r_owns));

endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          view,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] dout_q, dout_d;

    always_comb begin
        dout_d = dout_q;
        if (rd_en) dout_d = {DW{view}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_q <= '1;
        else        dout_q <= dout_d;
    end

    assign dout = dout_q;

    // R10: register holds without a valid read
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dout_q));

    // R10: every bit carries the same view
    assert_uniform_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_q == '0) || (dout_q == '1));

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int AW   = 14,
    parameter int DW   = 8,
    parameter int NSEM = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sem_sel,
    input  logic          l_mem_en,
    input  logic [AW-1:0] l_addr,
    input  logic          l_wr,
    input  logic          l_rd,
    input  logic          l_din,
    output logic [DW-1:0] l_dout,
    input  logic          r_sem_sel,
    input  logic          r_mem_en,
    input  logic [AW-1:0] r_addr,
    input  logic          r_wr,
    input  logic          r_rd,
    input  logic          r_din,
    output logic [DW-1:0] r_dout
);

    localparam int IW = $clog2(NSEM);

    logic [NSEM-1:0] l_claim, l_drop, r_claim, r_drop;
    logic [NSEM-1:0] l_owns, r_owns;
    logic            l_rd_en, r_rd_en;
    logic [IW-1:0]   l_idx, r_idx;

    sem_port_decode #(.AW(AW), .NSEM(NSEM)) u_dec_l (
        .clk(clk), .rst_n(rst_n), .sem_sel(l_sem_sel), .mem_en(l_mem_en),
        .addr(l_addr), .wr(l_wr), .rd(l_rd), .din(l_din),
        .claim_vec(l_claim), .drop_vec(l_drop), .rd_en(l_rd_en), .idx(l_idx)
    );

    sem_port_decode #(.AW(AW), .NSEM(NSEM)) u_dec_r (
        .clk(clk), .rst_n(rst_n), .sem_sel(r_sem_sel), .mem_en(r_mem_en),
        .addr(r_addr), .wr(r_wr), .rd(r_rd), .din(r_din),
        .claim_vec(r_claim), .drop_vec(r_drop), .rd_en(r_rd_en), .idx(r_idx)
    );

    for (genvar i = 0; i < NSEM; i++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_claim(l_claim[i]), .l_drop(l_drop[i]),
            .r_claim(r_claim[i]), .r_drop(r_drop[i]),
            .l_owns(l_owns[i]), .r_owns(r_owns[i])
        );
    end

    sem_read_reg #(.DW(DW)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .view(~l_owns[l_idx]), .dout(l_dout)
    );

    sem_read_reg #(.DW(DW)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .view(~r_owns[r_idx]), .dout(r_dout)
    );

    // R4: a latch never has two owners
    assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_owns & r_owns) == '0);

    // R11: a latch with no strobe on it keeps its owner
    assert_independent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_claim | l_drop | r_claim | r_drop) == '0) |=> $stable(l_owns) && $stable(r_owns));

endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;

    localparam int AW = 14;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sem_sel, l_mem_en, l_wr, l_rd, l_din;
    logic          r_sem_sel, r_mem_en, r_wr, r_rd, r_din;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_dout, r_dout;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sem_bank #(.AW(AW), .DW(DW), .NSEM(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_addr(l_addr),
        .l_wr(l_wr), .l_rd(l_rd), .l_din(l_din), .l_dout(l_dout),
        .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_addr(r_addr),
        .r_wr(r_wr), .r_rd(r_rd), .r_din(r_din), .r_dout(r_dout)
    );

    task automatic idle();
        l_sem_sel = 0; l_mem_en = 0; l_addr = '0; l_wr = 0; l_rd = 0; l_din = 1;
        r_sem_sel = 0; r_mem_en = 0; r_addr = '0; r_wr = 0; r_rd = 0; r_din = 1;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one-cycle access on one side (0 = left, 1 = right)
    task automatic acc(input bit side, input bit sel, input bit men, input logic [AW-1:0] a,
                       input bit w, input bit r, input bit d);
        @(negedge clk);
        if (!side) begin
            l_sem_sel = sel; l_mem_en = men; l_addr = a; l_wr = w; l_rd = r; l_din = d;
        end else begin
            r_sem_sel = sel; r_mem_en = men; r_addr = a; r_wr = w; r_rd = r; r_din = d;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input bit side, input logic [AW-1:0] a, input bit d);
        acc(side, 1, 0, a, 1, 0, d);
    endtask

    task automatic rd_chk(input bit side, input logic [AW-1:0] a, input bit e, input string tag);
        acc(side, 1, 0, a, 0, 1, 0);
        chk(tag, side ? r_dout : l_dout, {DW{e}});
    endtask

    task automatic t_reset();
        chk("R1 left reg", l_dout, '1);
        chk("R1 right reg", r_dout, '1);
        rd_chk(0, 0, 1, "R1 left sem0");
        rd_chk(1, 7, 1, "R1 right sem7");
    endtask

    task automatic t_basic();
        wr(0, 2, 0);
        rd_chk(0, 2, 0, "R4 owner view");
        rd_chk(1, 2, 1, "R4 other view");
        wr(0, 2, 1);
        rd_chk(0, 2, 1, "R6 left after release");
        rd_chk(1, 2, 1, "R6 right after release");
        wr(1, 2, 0);
        rd_chk(1, 2, 0, "R4 right claims");
        wr(1, 2, 1);
    endtask

    task automatic t_nonowner();
        wr(0, 3, 0);
        wr(1, 3, 1);
        rd_chk(0, 3, 0, "R5 non-owner write one");
        wr(0, 3, 0);
        rd_chk(0, 3, 0, "R5 repeated claim");
        wr(0, 3, 1);
        rd_chk(1, 3, 1, "R5 freed after owner release");
    endtask

    task automatic t_handover();
        wr(0, 4, 0);
        wr(1, 4, 0);
        rd_chk(1, 4, 1, "R7 queued side still out");
        wr(0, 4, 1);
        rd_chk(1, 4, 0, "R7 new owner");
        rd_chk(0, 4, 1, "R7 former owner");
        wr(1, 4, 1);
        rd_chk(0, 4, 1, "R7 freed later");
    endtask

    task automatic t_cancel();
        wr(0, 5, 0);
        wr(1, 5, 0);
        wr(1, 5, 1);
        wr(0, 5, 1);
        rd_chk(1, 5, 1, "R8 right after withdraw");
        rd_chk(0, 5, 1, "R8 left after withdraw");
    endtask

    task automatic t_simul();
        @(negedge clk);
        l_sem_sel = 1; l_addr = 6; l_wr = 1; l_din = 0;
        r_sem_sel = 1; r_addr = 6; r_wr = 1; r_din = 0;
        @(negedge clk);
        idle();
        rd_chk(0, 6, 0, "R9 left wins");
        rd_chk(1, 6, 1, "R9 right loses");
        wr(0, 6, 1);
        rd_chk(1, 6, 0, "R9 right claim was queued");
        wr(1, 6, 1);
    endtask

    task automatic t_addr();
        wr(0, 14'h3FF9, 0);
        rd_chk(1, 14'h0001, 1, "R3 right sees index 1 held");
        rd_chk(0, 14'h2A01, 0, "R3 left owns via other high bits");
        rd_chk(1, 14'h0000, 1, "R11 index 0 untouched");
        wr(1, 0, 0);
        rd_chk(1, 0, 0, "R11 index 0 free to claim");
        wr(1, 0, 1);
        wr(0, 1, 1);
    endtask

    task automatic t_gate();
        acc(0, 1, 1, 0, 1, 0, 0);
        acc(0, 0, 0, 0, 1, 0, 0);
        rd_chk(1, 0, 1, "R2 gated writes ignored");
        wr(1, 0, 1);
        rd_chk(0, 0, 1, "R2 left still free");
        wr(0, 0, 0);
        acc(0, 1, 1, 0, 0, 1, 0);
        chk("R2 read with mem_en held", l_dout, '1);
        acc(0, 0, 0, 0, 0, 1, 0);
        chk("R2 read without select held", l_dout, '1);
        wr(0, 0, 1);
    endtask

    task automatic t_readreg();
        wr(0, 7, 0);
        wr(1, 7, 0);
        rd_chk(0, 7, 0, "R10 left owns");
        @(negedge clk);
        l_sem_sel = 1; l_addr = 7; l_wr = 1; l_din = 1;
        r_sem_sel = 1; r_addr = 7; r_rd = 1;
        @(negedge clk);
        idle();
        chk("R10 read takes pre-write view", r_dout, '1);
        chk("R10 left register held", l_dout, '0);
        rd_chk(1, 7, 0, "R10 next read sees handover");
        wr(1, 7, 1);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nonowner();
        t_handover();
        t_cancel();
        t_simul();
        t_addr();
        t_gate();
        t_readreg();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule